// File: doc/BRIEF.md
# UART Interrupt Status and Control Register

This block is the interrupt register of a UART. It holds two interrupt enables and two pending-status flags in one 8-bit register, and it drives a single interrupt request line. The receive source is the datapath's "receive FIFO not empty" level. The transmit source is the datapath's "transmit FIFO has space" level. Each source sets a sticky pending flag.

A read returns the register image and clears the pending flags. A write changes only the enable field. Software can therefore program enables without a read-modify-write of the status bits, and writing zero masks every source. A source that is still active after a clear sets its flag again on the next clock. The request line is the OR of the enabled pending flags, registered once.

The enable field sits in bits 5:4 (bit 5 receive, bit 4 transmit). The status field sits in bits 1:0 (bit 1 receive, bit 0 transmit). Bits 7:6 and 3:2 are unused.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, `rd_data_o` reads 0x00 and `irq_o` is low.
- R2: A write loads bit 5 of `wr_data_i` into the receive enable and bit 4 into the transmit enable. The new enables are visible on `rd_data_o` bits 5:4 the cycle after the write. With no write, the enables hold their value.
- R3: A write never changes status bits 1:0, whatever the written data.
- R4: `rx_not_empty_i` sampled high at a clock edge sets status bit 1 after that edge. Bit 1 then stays set until a read clears it.
- R5: `tx_not_full_i` sampled high at a clock edge sets status bit 0 after that edge. Bit 0 then stays set until a read clears it.
- R6: In a read cycle, `rd_data_o` shows the current status. The edge that ends the read clears status bits 1:0.
- R7: If a source is high in the same cycle as a read, its status bit is set after the edge; the set wins over the clear.
- R8: `irq_o` is high in the cycle after any status bit and its matching enable are both set. Otherwise it is low in that cycle.
- R9: Bits 7:6 and 3:2 of `rd_data_o` always read zero.
- R10: Writing 0x00 clears both enables, so `irq_o` is low from the second cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; only bits 5:4 are used |
| rd_en_i | input | 1 | Read strobe; clears the status bits at the edge |
| rd_data_o | output | 8 | Register image: enables in 5:4, status in 1:0 |
| rx_not_empty_i | input | 1 | Receive FIFO holds data (level) |
| tx_not_full_i | input | 1 | Transmit FIFO has space (level) |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency:
- A source level, a read clear and a write each show on `rd_data_o` one edge after they are sampled.
- `irq_o` follows the status and enables one edge after that, so it trails the source by two edges.

The bench drives inputs on the falling edge and compares the outputs just before the next rising edge. Its model advances at each rising edge, using the values from before that edge, so every comparison falls in the cycle where the output is due.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 2;
  localparam int ENA_LSB = 4;
  localparam int STS_LSB = 0;
  localparam int SRC_TX  = 0;
  localparam int SRC_RX  = 1;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_bits_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (wr_en_i) en_o <= wr_bits_i;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_o));
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> en_o == $past(wr_bits_i));
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;  // set beats clear
    else if (clr_i)  pend_o <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(pend_i & en_i);
  end

  assert_irq_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_i & en_i)) |=> irq_o);
  assert_irq_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  input  logic         rx_not_empty_i,
  input  logic         tx_not_full_i,
  output logic         irq_o
);
  src_vec_t src, pend, en;

  always_comb begin
    src         = '0;
    src[SRC_RX] = rx_not_empty_i;
    src[SRC_TX] = tx_not_full_i;
  end

  uart_irq_enable #(.N(NUM_SRC)) i_enable (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_bits_i (wr_data_i[ENA_LSB +: NUM_SRC]),
    .en_o      (en)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    uart_irq_pend i_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src[g]),
      .clr_i  (rd_en_i),
      .pend_o (pend[g])
    );
  end

  uart_irq_req #(.N(NUM_SRC)) i_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .en_i   (en),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[ENA_LSB +: NUM_SRC]  = en;
    rd_data_o[STS_LSB +: NUM_SRC]  = pend;
  end

  assert_write_keeps_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && !rx_not_empty_i && !tx_not_full_i)
      |=> rd_data_o[1:0] == $past(rd_data_o[1:0]));
  assert_rx_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_not_empty_i |=> rd_data_o[1]);
  assert_tx_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_not_full_i |=> rd_data_o[0]);
  assert_zero_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == '0) |=> rd_data_o[5:4] == 2'b00);
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rx = 1'b0, tx = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state: en[1]=rx enable, st[1]=rx status
  logic [1:0] m_en = '0, m_st = '0;
  logic       m_irq = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rx_not_empty_i(rx),
    .tx_not_full_i(tx), .irq_o(irq)
  );

  function automatic logic [7:0] img(logic [1:0] en, logic [1:0] st);
    return {2'b00, en, 2'b00, st};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R2 enables"}, {6'd0, rd_data[5:4]}, {6'd0, m_en});
    chk({ctx, " R4 rx status"}, {7'd0, rd_data[1]}, {7'd0, m_st[1]});
    chk({ctx, " R5 tx status"}, {7'd0, rd_data[0]}, {7'd0, m_st[0]});
    chk({ctx, " R9 unused bits"}, {4'd0, rd_data[7:6], rd_data[3:2]}, 8'd0);
    chk({ctx, " R8 irq"}, {7'd0, irq}, {7'd0, m_irq});
  endtask

  // drive on falling edge, check just before rising edge, advance model at edge
  task automatic cyc(logic w, logic [7:0] wd, logic r, logic srx, logic stx, string ctx);
    @(negedge clk);
    wr_en = w; wr_data = wd; rd_en = r; rx = srx; tx = stx;
    #1;
    check_all(ctx);
    @(posedge clk);
    m_irq = |(m_st & m_en);
    m_st  = {srx, stx} | (m_st & {2{~r}});
    if (w) m_en = wd[5:4];
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 150000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset image", rd_data, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'd0);

    // R2/R9: write all ones, only 5:4 land
    cyc(1, 8'hFF, 0, 0, 0, "wr_ff");
    cyc(0, 8'h00, 0, 0, 0, "after_wr");
    chk("R2 readback", rd_data, 8'h30);
    // R3: write with status bits pattern, no sources -> status stays 0
    cyc(1, 8'h0F, 0, 0, 0, "wr_0f");
    cyc(0, 8'h00, 0, 0, 0, "after_wr0f");
    chk("R3 status untouched", rd_data, 8'h00);
    // R4: rx sets bit 1 and sticks
    cyc(1, 8'h20, 0, 1, 0, "rx_pulse");
    cyc(0, 8'h00, 0, 0, 0, "rx_stick");
    chk("R4 rx set", rd_data, 8'h22);
    cyc(0, 8'h00, 0, 0, 0, "rx_irq");
    chk("R8 irq rx enabled", {7'd0, irq}, 8'd1);
    // R3: write while status pending keeps it
    cyc(1, 8'h10, 0, 0, 0, "wr_keep");
    cyc(0, 8'h00, 0, 0, 0, "wr_keep2");
    chk("R3 status kept on write", rd_data, 8'h12);
    // R6: read shows status then clears
    cyc(0, 8'h00, 1, 0, 0, "read");
    cyc(0, 8'h00, 0, 0, 0, "after_read");
    chk("R6 cleared", rd_data, 8'h10);
    // R5 + R7: tx held high across a read
    cyc(0, 8'h00, 0, 0, 1, "tx_set");
    cyc(0, 8'h00, 1, 0, 1, "tx_read_set");
    cyc(0, 8'h00, 0, 0, 0, "tx_after");
    chk("R7 set wins", rd_data, 8'h11);
    chk("R5 tx set", {7'd0, rd_data[0]}, 8'd1);
    // R10: writing zero drops irq two cycles later
    cyc(1, 8'h00, 0, 0, 0, "wr_zero");
    cyc(0, 8'h00, 0, 0, 0, "wr_zero1");
    cyc(0, 8'h00, 0, 0, 0, "wr_zero2");
    chk("R10 irq off", {7'd0, irq}, 8'd0);
    chk("R10 enables off", rd_data, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] == 0, r[15:8], r[7:5] == 0, r[16] & r[17], r[18] & r[19], "rand");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule